// File: doc/BRIEF.md
# Fixed-Point Line Segment Clipper

This block trims one 2D line segment to an axis-aligned rectangular window. A single-cycle start pulse captures two endpoints and the four window edges. The block then labels each endpoint with a 4-bit region code and settles the easy cases at once. If both endpoints lie inside, the segment is kept as it is. If both lie beyond the same edge, the segment is dropped. Every other segment passes through two intersection stages. Each outside endpoint is first pulled onto the left or right edge. It may then be pulled again onto the top or bottom edge. A final test on the two line parameters decides whether the trimmed segment survives.

Both endpoints are handled side by side by identical datapaths. The sequencing is a five-state machine:
- `ST_IDLE` waits for start and captures the inputs.
- `ST_CODE` registers the codes. On a trivial outcome it finishes and returns to `ST_IDLE`; otherwise it moves on to `ST_XCLIP`.
- `ST_XCLIP` performs the horizontal-edge clip.
- `ST_YCLIP` performs the conditional vertical-edge re-clip.
- `ST_FINAL` issues the verdict and returns to `ST_IDLE`.

Only one segment is in flight at a time. The results stay on the outputs until a later segment completes.

Top module: `seg_clipper`

## Requirements
- R1: All coordinate, window-edge, parameter and result ports are 24-bit two's-complement numbers with 12 fraction bits, so the raw value 4096 is 1.0.
- R2: Each endpoint's region code is reported on code1_o/code2_o. Bit 0 is set when x < left edge and bit 1 when x > right edge. Bit 2 is set when y > top edge and bit 3 when y < bottom edge. All comparisons are strict signed comparisons, and a point inside or on the window has code 0.
- R3: When both codes are 0 the segment is accepted, both new vertices equal the input endpoints, and both parameters are 0.
- R4: When the bitwise AND of the two codes is nonzero the segment is rejected, both new vertices equal the input endpoints, and both parameters are 0.
- R5: In the horizontal stage, an endpoint with bit 0 or bit 1 set takes X as the left edge (bit 0) or the right edge (bit 1). It then gets t = trunc((X − xi)·4096 / (x2 − x1)), rounded toward zero, new x = X and new y = yi + ((t·(y2 − y1)) >>> 12), where >>> is an arithmetic shift.
- R6: An endpoint whose code is 0 keeps its input coordinates as its new vertex and reports a parameter of 0.
- R7: In the vertical stage an endpoint is re-clipped only in two cases: bit 2 is set and its current new y is greater than the top edge, or bit 3 is set and its current new y is less than the bottom edge. The re-clip uses the top edge (bit 2) or the bottom edge (bit 3) as Y. It overwrites t = trunc((Y − yi)·4096 / (y2 − y1)), new y = Y and new x = xi + ((t·(x2 − x1)) >>> 12). An endpoint with only a vertical bit set is therefore re-clipped from its input position.
- R8: After the intersection stages, the segment is rejected when |t1| + |t2| ≥ 4096 raw and accepted otherwise.
- R9: done_o is high for exactly one cycle per segment, and in that cycle exactly one of accept_o and reject_o is high.
- R10: A start pulse that arrives while a segment is in flight is ignored. This covers the span from the edge that samples the start up to the edge that raises done_o.
- R11: Reset clears every output to 0. The vertex, parameter and verdict outputs change only in the cycle where done_o is high. The codes are updated on the first edge after the start is sampled.
- R12: done_o is visible after the first rising edge following the edge that samples start_i for a trivial accept or reject, and after the fourth such edge otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a segment (sampled in idle only) |
| x1_i | input | 24 | Endpoint 1 x |
| y1_i | input | 24 | Endpoint 1 y |
| x2_i | input | 24 | Endpoint 2 x |
| y2_i | input | 24 | Endpoint 2 y |
| xmin_i | input | 24 | Left window edge |
| ymin_i | input | 24 | Bottom window edge |
| xmax_i | input | 24 | Right window edge |
| ymax_i | input | 24 | Top window edge |
| code1_o | output | 4 | Region code of endpoint 1 |
| code2_o | output | 4 | Region code of endpoint 2 |
| t1_o | output | 24 | Parameter of endpoint 1 |
| t2_o | output | 24 | Parameter of endpoint 2 |
| xn1_o | output | 24 | New vertex 1 x |
| yn1_o | output | 24 | New vertex 1 y |
| xn2_o | output | 24 | New vertex 2 x |
| yn2_o | output | 24 | New vertex 2 y |
| accept_o | output | 1 | Segment kept |
| reject_o | output | 1 | Segment dropped |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The hardest situation to reach is an endpoint that lies past a corner of the window and has no shared code bit with the other endpoint. It needs the horizontal clip, then a vertical re-clip, and sometimes a final rejection because |t1| + |t2| reaches one. The stimulus reaches it with hand-placed diagonal segments that cross or just miss a corner. It adds a segment whose horizontal clip already lands inside the vertical range, so the re-clip must be skipped. Randomised endpoints spread well beyond a fixed window then cover the remaining mixes of codes. A second start issued mid-flight with different data shows that the first segment's results come out untouched.

// File: rtl/seg_clip_pkg.sv
package seg_clip_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CODE,
        ST_XCLIP,
        ST_YCLIP,
        ST_FINAL
    } clip_state_t;

    localparam int BIT_LEFT  = 0;
    localparam int BIT_RIGHT = 1;
    localparam int BIT_ABOVE = 2;
    localparam int BIT_BELOW = 3;
endpackage

// File: rtl/seg_clip_region.sv
module seg_clip_region #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] px,
    input  logic signed [W-1:0] py,
    input  logic signed [W-1:0] xlo,
    input  logic signed [W-1:0] xhi,
    input  logic signed [W-1:0] ylo,
    input  logic signed [W-1:0] yhi,
    output logic [3:0]          code
);
    import seg_clip_pkg::*;

    always_comb begin
        code            = '0;
        code[BIT_LEFT]  = px < xlo;
        code[BIT_RIGHT] = px > xhi;
        code[BIT_ABOVE] = py > yhi;
        code[BIT_BELOW] = py < ylo;
    end
endmodule

// File: rtl/seg_clip_ray.sv
// Intersection of the segment with one boundary line.
// The 'a' axis is the one the boundary fixes; 'b' is the other axis.
module seg_clip_ray #(
    parameter int W    = 24,
    parameter int FRAC = 12
) (
    input  logic signed [W-1:0] base_a,
    input  logic signed [W-1:0] base_b,
    input  logic signed [W-1:0] bound,
    input  logic signed [W:0]   span_a,
    input  logic signed [W:0]   span_b,
    output logic signed [W-1:0] t,
    output logic signed [W-1:0] b_new
);
    localparam int SW = W + 1;
    localparam int PW = 2 * W + 2;

    logic signed [SW-1:0] num;
    logic signed [PW-1:0] n_ext;
    logic signed [PW-1:0] d_safe;
    logic signed [PW-1:0] q_all;
    logic signed [PW-1:0] t_ext;
    logic signed [PW-1:0] sb_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] prod_sh;
    logic                 span_zero;

    assign num       = $signed({bound[W-1], bound}) - $signed({base_a[W-1], base_a});
    assign span_zero = (span_a == '0);

    always_comb begin
        n_ext = {{(PW-SW){num[SW-1]}}, num};
        n_ext = n_ext <<< FRAC;
        if (span_zero) begin
            d_safe = {{(PW-1){1'b0}}, 1'b1};
        end else begin
            d_safe = {{(PW-SW){span_a[SW-1]}}, span_a};
        end
        q_all = n_ext / d_safe;
    end

    assign t       = span_zero ? '0 : W'(q_all);
    assign t_ext   = {{(PW-W){t[W-1]}}, t};
    assign sb_ext  = {{(PW-SW){span_b[SW-1]}}, span_b};
    assign prod    = t_ext * sb_ext;
    assign prod_sh = prod >>> FRAC;
    assign b_new   = base_b + W'(prod_sh);
endmodule

// File: rtl/seg_clipper.sv
module seg_clipper
    import seg_clip_pkg::*;
#(
    parameter int W    = 24,
    parameter int FRAC = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic signed [W-1:0] x1_i,
    input  logic signed [W-1:0] y1_i,
    input  logic signed [W-1:0] x2_i,
    input  logic signed [W-1:0] y2_i,
    input  logic signed [W-1:0] xmin_i,
    input  logic signed [W-1:0] ymin_i,
    input  logic signed [W-1:0] xmax_i,
    input  logic signed [W-1:0] ymax_i,
    output logic [3:0]          code1_o,
    output logic [3:0]          code2_o,
    output logic signed [W-1:0] t1_o,
    output logic signed [W-1:0] t2_o,
    output logic signed [W-1:0] xn1_o,
    output logic signed [W-1:0] yn1_o,
    output logic signed [W-1:0] xn2_o,
    output logic signed [W-1:0] yn2_o,
    output logic                accept_o,
    output logic                reject_o,
    output logic                done_o
);
    localparam int SW = W + 1;
    localparam int AW = W + 2;
    localparam logic [AW-1:0] ONE = AW'(1) << FRAC;

    clip_state_t state_q, state_d;

    logic signed [W-1:0]  px [2];
    logic signed [W-1:0]  py [2];
    logic signed [W-1:0]  wxlo, wxhi, wylo, wyhi;
    logic [3:0]           code_c [2];
    logic [3:0]           code_q [2];
    logic signed [SW-1:0] dx, dy;

    logic signed [W-1:0]  xb_sel [2];
    logic signed [W-1:0]  yb_sel [2];
    logic signed [W-1:0]  tx [2];
    logic signed [W-1:0]  ty [2];
    logic signed [W-1:0]  y_on_x [2];
    logic signed [W-1:0]  x_on_y [2];
    logic                 redo_y [2];
    logic [SW-1:0]        mag_t [2];

    logic signed [W-1:0]  cur_t  [2];
    logic signed [W-1:0]  cur_xn [2];
    logic signed [W-1:0]  cur_yn [2];

    logic                 all_in, shared_out, too_long;
    logic [AW-1:0]        mag_sum;

    assign dx = $signed({px[1][W-1], px[1]}) - $signed({px[0][W-1], px[0]});
    assign dy = $signed({py[1][W-1], py[1]}) - $signed({py[0][W-1], py[0]});

    for (genvar i = 0; i < 2; i++) begin : g_end
        seg_clip_region #(.W(W)) u_region (
            .px   (px[i]),
            .py   (py[i]),
            .xlo  (wxlo),
            .xhi  (wxhi),
            .ylo  (wylo),
            .yhi  (wyhi),
            .code (code_c[i])
        );

        assign xb_sel[i] = code_q[i][BIT_LEFT]  ? wxlo : wxhi;
        assign yb_sel[i] = code_q[i][BIT_ABOVE] ? wyhi : wylo;

        seg_clip_ray #(.W(W), .FRAC(FRAC)) u_xray (
            .base_a (px[i]),
            .base_b (py[i]),
            .bound  (xb_sel[i]),
            .span_a (dx),
            .span_b (dy),
            .t      (tx[i]),
            .b_new  (y_on_x[i])
        );

        seg_clip_ray #(.W(W), .FRAC(FRAC)) u_yray (
            .base_a (py[i]),
            .base_b (px[i]),
            .bound  (yb_sel[i]),
            .span_a (dy),
            .span_b (dx),
            .t      (ty[i]),
            .b_new  (x_on_y[i])
        );

        assign redo_y[i] = (code_q[i][BIT_ABOVE] && (cur_yn[i] > wyhi)) ||
                           (code_q[i][BIT_BELOW] && (cur_yn[i] < wylo));

        assign mag_t[i] = cur_t[i][W-1] ? SW'(-$signed({cur_t[i][W-1], cur_t[i]}))
                                        : {1'b0, cur_t[i]};
    end

    assign all_in     = (code_c[0] == 4'd0) && (code_c[1] == 4'd0);
    assign shared_out = (code_c[0] & code_c[1]) != 4'd0;
    assign mag_sum    = {1'b0, mag_t[0]} + {1'b0, mag_t[1]};
    assign too_long   = mag_sum >= ONE;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CODE;
            ST_CODE:  state_d = (all_in || shared_out) ? ST_IDLE : ST_XCLIP;
            ST_XCLIP: state_d = ST_YCLIP;
            ST_YCLIP: state_d = ST_FINAL;
            ST_FINAL: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                px[i]     <= '0;
                py[i]     <= '0;
                code_q[i] <= '0;
                cur_t[i]  <= '0;
                cur_xn[i] <= '0;
                cur_yn[i] <= '0;
            end
            wxlo     <= '0;
            wxhi     <= '0;
            wylo     <= '0;
            wyhi     <= '0;
            code1_o  <= '0;
            code2_o  <= '0;
            t1_o     <= '0;
            t2_o     <= '0;
            xn1_o    <= '0;
            yn1_o    <= '0;
            xn2_o    <= '0;
            yn2_o    <= '0;
            accept_o <= 1'b0;
            reject_o <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        px[0] <= x1_i;
                        py[0] <= y1_i;
                        px[1] <= x2_i;
                        py[1] <= y2_i;
                        wxlo  <= xmin_i;
                        wxhi  <= xmax_i;
                        wylo  <= ymin_i;
                        wyhi  <= ymax_i;
                    end
                end
                ST_CODE: begin
                    code_q[0] <= code_c[0];
                    code_q[1] <= code_c[1];
                    code1_o   <= code_c[0];
                    code2_o   <= code_c[1];
                    if (all_in || shared_out) begin
                        done_o   <= 1'b1;
                        accept_o <= all_in;
                        reject_o <= !all_in;
                        t1_o     <= '0;
                        t2_o     <= '0;
                        xn1_o    <= px[0];
                        yn1_o    <= py[0];
                        xn2_o    <= px[1];
                        yn2_o    <= py[1];
                    end
                end
                ST_XCLIP: begin
                    for (int i = 0; i < 2; i++) begin
                        if (code_q[i][BIT_RIGHT:BIT_LEFT] != 2'b00) begin
                            cur_t[i]  <= tx[i];
                            cur_xn[i] <= xb_sel[i];
                            cur_yn[i] <= y_on_x[i];
                        end else begin
                            cur_t[i]  <= '0;
                            cur_xn[i] <= px[i];
                            cur_yn[i] <= py[i];
                        end
                    end
                end
                ST_YCLIP: begin
                    for (int i = 0; i < 2; i++) begin
                        if (redo_y[i]) begin
                            cur_t[i]  <= ty[i];
                            cur_xn[i] <= x_on_y[i];
                            cur_yn[i] <= yb_sel[i];
                        end
                    end
                end
                ST_FINAL: begin
                    done_o   <= 1'b1;
                    accept_o <= !too_long;
                    reject_o <= too_long;
                    t1_o     <= cur_t[0];
                    t2_o     <= cur_t[1];
                    xn1_o    <= cur_xn[0];
                    yn1_o    <= cur_yn[0];
                    xn2_o    <= cur_xn[1];
                    yn2_o    <= cur_yn[1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/seg_clip_checks.sv
module seg_clip_checks #(
    parameter int W    = 24,
    parameter int FRAC = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          code1_o,
    input logic [3:0]          code2_o,
    input logic signed [W-1:0] t1_o,
    input logic signed [W-1:0] t2_o,
    input logic signed [W-1:0] xn1_o,
    input logic signed [W-1:0] yn1_o,
    input logic signed [W-1:0] xn2_o,
    input logic signed [W-1:0] yn2_o,
    input logic                accept_o,
    input logic                reject_o,
    input logic                done_o
);
    localparam int AW = W + 2;
    localparam logic [AW-1:0] ONE = AW'(1) << FRAC;

    logic [W:0]    m1, m2;
    logic [AW-1:0] msum;

    assign m1   = t1_o[W-1] ? (W+1)'(-$signed({t1_o[W-1], t1_o})) : {1'b0, t1_o};
    assign m2   = t2_o[W-1] ? (W+1)'(-$signed({t2_o[W-1], t2_o})) : {1'b0, t2_o};
    assign msum = {1'b0, m1} + {1'b0, m2};

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R9
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (accept_o != reject_o));  // R9
    AST_INSIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && code1_o == 4'd0 && code2_o == 4'd0) |-> (accept_o && t1_o == '0 && t2_o == '0));  // R3
    AST_SHARED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (code1_o & code2_o) != 4'd0) |-> reject_o);  // R4
    AST_ZERO_CODE_PARAM1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && code1_o == 4'd0) |-> (t1_o == '0));  // R6
    AST_ZERO_CODE_PARAM2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && code2_o == 4'd0) |-> (t2_o == '0));  // R6
    AST_ACCEPT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && accept_o) |-> (msum < ONE));  // R8
    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(xn1_o) && $stable(yn1_o) && $stable(xn2_o) && $stable(yn2_o) &&
                     $stable(t1_o) && $stable(t2_o) && $stable(accept_o) && $stable(reject_o)));  // R11
endmodule

bind seg_clipper seg_clip_checks #(.W(W), .FRAC(FRAC)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .code1_o  (code1_o),
    .code2_o  (code2_o),
    .t1_o     (t1_o),
    .t2_o     (t2_o),
    .xn1_o    (xn1_o),
    .yn1_o    (yn1_o),
    .xn2_o    (xn2_o),
    .yn2_o    (yn2_o),
    .accept_o (accept_o),
    .reject_o (reject_o),
    .done_o   (done_o)
);

// File: tb/sim_seg_clipper.sv
module sim_seg_clipper;
    localparam int W    = 24;
    localparam int FRAC = 12;
    localparam longint SC = 64'sd1 << FRAC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic signed [W-1:0] x1_i = '0, y1_i = '0, x2_i = '0, y2_i = '0;
    logic signed [W-1:0] xmin_i = '0, ymin_i = '0, xmax_i = '0, ymax_i = '0;
    logic [3:0] code1_o, code2_o;
    logic signed [W-1:0] t1_o, t2_o, xn1_o, yn1_o, xn2_o, yn2_o;
    logic accept_o, reject_o, done_o;

    always #2 clk = ~clk;

    seg_clipper #(.W(W), .FRAC(FRAC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .x1_i(x1_i), .y1_i(y1_i), .x2_i(x2_i), .y2_i(y2_i),
        .xmin_i(xmin_i), .ymin_i(ymin_i), .xmax_i(xmax_i), .ymax_i(ymax_i),
        .code1_o(code1_o), .code2_o(code2_o), .t1_o(t1_o), .t2_o(t2_o),
        .xn1_o(xn1_o), .yn1_o(yn1_o), .xn2_o(xn2_o), .yn2_o(yn2_o),
        .accept_o(accept_o), .reject_o(reject_o), .done_o(done_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // reference model state
    longint m_t[2], m_xn[2], m_yn[2];
    int     m_code[2];
    bit     m_acc;
    string  m_vtag;
    string  m_etag[2];
    longint h_t[2], h_xn[2], h_yn[2];
    bit     h_acc;
    bit     pend = 1'b0;
    bit     have_last = 1'b0;
    int     rem = 0;

    function automatic longint fdiv(longint n, longint d);
        return (n * SC) / d;
    endfunction

    function automatic longint fmul(longint t, longint s);
        return (t * s) >>> FRAC;
    endfunction

    function automatic int region(longint x, longint y, longint xl, longint yl, longint xh, longint yh);
        int c = 0;
        if (x < xl) c += 1;
        if (x > xh) c += 2;
        if (y > yh) c += 4;
        if (y < yl) c += 8;
        return c;
    endfunction

    function automatic longint iabs(longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Behavioural model: returns the latency in edges after the start edge.
    task automatic model(input longint ax, input longint ay, input longint bx, input longint by,
                         input longint xl, input longint yl, input longint xh, input longint yh,
                         output int lat);
        longint px[2], py[2], dx, dy, bnd;
        px[0] = ax; py[0] = ay; px[1] = bx; py[1] = by;
        dx = bx - ax; dy = by - ay;
        for (int i = 0; i < 2; i++) begin
            m_code[i] = region(px[i], py[i], xl, yl, xh, yh);
            m_t[i] = 0; m_xn[i] = px[i]; m_yn[i] = py[i];
        end
        if (m_code[0] == 0 && m_code[1] == 0) begin
            m_acc = 1'b1; m_vtag = "R3"; m_etag[0] = "R3"; m_etag[1] = "R3"; lat = 1;
        end else if ((m_code[0] & m_code[1]) != 0) begin
            m_acc = 1'b0; m_vtag = "R4"; m_etag[0] = "R4"; m_etag[1] = "R4"; lat = 1;
        end else begin
            for (int i = 0; i < 2; i++) begin
                m_etag[i] = (m_code[i] == 0) ? "R6" : "R5";
                if ((m_code[i] & 3) != 0) begin
                    bnd = ((m_code[i] & 1) != 0) ? xl : xh;
                    m_t[i] = fdiv(bnd - px[i], dx);
                    m_xn[i] = bnd;
                    m_yn[i] = py[i] + fmul(m_t[i], dy);
                end
                if ((((m_code[i] & 4) != 0) && m_yn[i] > yh) || (((m_code[i] & 8) != 0) && m_yn[i] < yl)) begin
                    bnd = ((m_code[i] & 4) != 0) ? yh : yl;
                    m_t[i] = fdiv(bnd - py[i], dy);
                    m_yn[i] = bnd;
                    m_xn[i] = px[i] + fmul(m_t[i], dx);
                    m_etag[i] = "R7";
                end
            end
            m_acc = (iabs(m_t[0]) + iabs(m_t[1])) < SC;
            m_vtag = "R8";
            lat = 4;
        end
    endtask

    task automatic observe();
        bit exp_done;
        exp_done = pend && (rem == 0);
        chk(done_o === exp_done, "R12", "done_o", longint'(done_o), longint'(exp_done));
        if (exp_done) begin
            chk(accept_o != reject_o, "R9", "accept_o^reject_o", longint'(accept_o ^ reject_o), 1);
            chk(int'(code1_o) == m_code[0], "R2", "code1_o", longint'(code1_o), longint'(m_code[0]));
            chk(int'(code2_o) == m_code[1], "R2", "code2_o", longint'(code2_o), longint'(m_code[1]));
            chk(accept_o == m_acc, m_vtag, "accept_o", longint'(accept_o), longint'(m_acc));
            chk(longint'(t1_o) == m_t[0], m_etag[0], "t1_o", longint'(t1_o), m_t[0]);
            chk(longint'(xn1_o) == m_xn[0], m_etag[0], "xn1_o", longint'(xn1_o), m_xn[0]);
            chk(longint'(yn1_o) == m_yn[0], m_etag[0], "yn1_o", longint'(yn1_o), m_yn[0]);
            chk(longint'(t2_o) == m_t[1], m_etag[1], "t2_o", longint'(t2_o), m_t[1]);
            chk(longint'(xn2_o) == m_xn[1], m_etag[1], "xn2_o", longint'(xn2_o), m_xn[1]);
            chk(longint'(yn2_o) == m_yn[1], m_etag[1], "yn2_o", longint'(yn2_o), m_yn[1]);
            for (int i = 0; i < 2; i++) begin
                h_t[i] = m_t[i]; h_xn[i] = m_xn[i]; h_yn[i] = m_yn[i];
            end
            h_acc = m_acc;
            have_last = 1'b1;
            pend = 1'b0;
        end else if (have_last) begin
            chk(longint'(xn1_o) == h_xn[0] && longint'(yn2_o) == h_yn[1], "R11", "held vertex",
                longint'(xn1_o), h_xn[0]);
            chk(longint'(t2_o) == h_t[1] && accept_o == h_acc, "R11", "held t2/verdict",
                longint'(t2_o), h_t[1]);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (pend) rem--;
        @(negedge clk);
        observe();
    endtask

    task automatic go(input longint ax, input longint ay, input longint bx, input longint by,
                      input longint xl, input longint yl, input longint xh, input longint yh);
        int lat;
        x1_i = W'(ax); y1_i = W'(ay); x2_i = W'(bx); y2_i = W'(by);
        xmin_i = W'(xl); ymin_i = W'(yl); xmax_i = W'(xh); ymax_i = W'(yh);
        start_i = 1'b1;
        if (!pend) begin
            model(ax, ay, bx, by, xl, yl, xh, yh, lat);
            pend = 1'b1;
            rem = lat + 1;
        end
        tick();
        start_i = 1'b0;
    endtask

    task automatic finish_seg();
        while (pend) tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        longint held;
        repeat (3) @(negedge clk);
        // reset state (R11)
        chk(done_o == 1'b0 && accept_o == 1'b0 && reject_o == 1'b0, "R11", "reset flags",
            longint'({done_o, accept_o, reject_o}), 0);
        chk(xn1_o == '0 && t1_o == '0 && code1_o == 4'd0, "R11", "reset values", longint'(xn1_o), 0);
        rst_n = 1'b1;
        tick();

        // corner-crossing case, Q12.12 operands (R1, R5, R7)
        go(-100*SC, 800*SC, 1200*SC, -200*SC, 0, 0, 1023*SC, 799*SC);
        finish_seg();
        chk(longint'(xn2_o) == 64'sd3850500, "R1", "xn2_o raw", longint'(xn2_o), 64'sd3850500);
        // one endpoint inside, right clip only (R5, R6)
        go(100*SC, 200*SC, 600*SC, 40*SC, 0, 0, 511*SC, 511*SC);
        finish_seg();
        // fully inside (R3)
        go(10*SC + 77, 20*SC, 300*SC, 400*SC + 2048, 0, 0, 511*SC, 511*SC);
        finish_seg();
        // both left of window (R4)
        go(-5*SC, 10*SC, -50*SC, 300*SC, 0, 0, 511*SC, 511*SC);
        finish_seg();
        // misses the corner: no shared bit, parameter sum too large (R8, R7)
        go(-10*SC, 5*SC, 5*SC, -10*SC, 0, 0, 100*SC, 100*SC);
        finish_seg();
        // vertical-only endpoint re-clipped from its input (R7)
        go(50*SC, 150*SC, 60*SC, 50*SC, 0, 0, 100*SC, 100*SC);
        finish_seg();
        // boundary points are inside (R2)
        go(0, 100*SC, 100*SC, 0, 0, 0, 100*SC, 100*SC);
        finish_seg();

        // start while busy is ignored (R10)
        go(-100*SC, 800*SC, 1200*SC, -200*SC, 0, 0, 1023*SC, 799*SC);
        held = m_xn[1];
        go(1*SC, 1*SC, 2*SC, 2*SC, 0, 0, 10*SC, 10*SC);
        tick();
        go(-9*SC, -9*SC, -8*SC, -8*SC, 0, 0, 10*SC, 10*SC);
        finish_seg();
        chk(longint'(xn2_o) == held, "R10", "xn2_o after busy start", longint'(xn2_o), held);

        // back-to-back starts on consecutive idle cycles (R12)
        go(-20*SC, 30*SC, 40*SC, 30*SC, 0, 0, 100*SC, 100*SC);
        while (pend) tick();
        go(5*SC, 5*SC, 6*SC, 6*SC, 0, 0, 100*SC, 100*SC);
        finish_seg();

        // randomised mix
        for (int k = 0; k < 80; k++) begin
            longint c[4];
            for (int j = 0; j < 4; j++) begin
                c[j] = (longint'($urandom_range(0, 1800)) - 400) * SC + longint'($urandom_range(0, 4095));
            end
            if ((k % 2) == 0) go(c[0], c[1], c[2], c[3], 0, 0, 1023*SC, 799*SC);
            else              go(c[0], c[1], c[2], c[3], 200*SC, -100*SC, 700*SC, 600*SC + 123);
            finish_seg();
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule